// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the horizontal and vertical timing for a parallel RGB panel. It advances by one position per dot clock. Its outputs are a horizontal sync, a vertical sync, a data-enable pin, a pixel request strobe for the pixel data path, and single-cycle pulses that mark the start of each line and each frame.

Each axis is described by a small set of values:

- a total period;
- a sync pulse width;
- a wait count, which is the sync width plus the back porch;
- an active length.

The active window of an axis opens when its wait count expires and stays open for the active length. Polarity bits set the active level of each pin. A separate drive bit decides whether the data-enable pin is used at all. A master sync-enable input starts and stops the raster.

The block copies every configuration input into a shadow copy. It does this at each frame boundary, and continuously while the raster is stopped. A host may therefore rewrite the timing at any moment without tearing the frame that is being scanned.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted, pix_req, line_start and frame_start are low, and hsync_o, vsync_o and de_o are high. The held polarities reset to 0, which means active-low.
- R2: While running, the horizontal position steps through 0 to line_period-1 and then wraps to 0. line_start is high exactly when the position is 0, so it pulses once every line_period cycles.
- R3: While running, the frame holds frame_lines lines. frame_start is high only at horizontal position 0 of line 0, and it is never high without line_start.
- R4: hsync_o is at its active level for horizontal positions below hsync_width. The active level is high when hs_pol_hi is 1 and low when it is 0. hsync_o is at the inactive level elsewhere.
- R5: vsync_o is at its active level for the whole of every line whose index is below vsync_width, measured in lines. The active level is high when vs_pol_hi is 1.
- R6: pix_req is high exactly when both conditions hold:
  - the horizontal position is in [h_wait, h_wait+h_active);
  - the line index is in [v_wait, v_wait+v_active).
- R7: When de_drive is 1, de_o is at its active level exactly when pix_req is high. The active level is high when de_pol_hi is 1. When de_drive is 0, de_o stays at the inactive level.
- R8: While the sync enable seen at the last clock edge is 0, the following hold:
  - hsync_o, vsync_o and de_o sit at their inactive levels;
  - all strobes are low;
  - the counters hold at 0.
  In the first cycle after an edge that samples sync_en high, frame_start and line_start are high at position (0,0).
- R9: A configuration change made while running takes effect at the next frame start and not before. The current frame completes with the values held when it began.
- R10: Each counter wraps at its held period minus one. A period of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Master enable for the raster and the sync outputs |
| hs_pol_hi | input | 1 | 1 makes the horizontal sync active-high |
| vs_pol_hi | input | 1 | 1 makes the vertical sync active-high |
| de_pol_hi | input | 1 | 1 makes the data-enable pin active-high |
| de_drive | input | 1 | 1 lets the block drive data-enable |
| line_period | input | 18 | Dot clocks per line, total |
| hsync_width | input | 14 | Horizontal sync width in dot clocks |
| h_wait | input | 12 | Horizontal sync width plus back porch |
| h_active | input | 18 | Active pixels per line |
| frame_lines | input | 16 | Lines per frame, total |
| vsync_width | input | 18 | Vertical sync width in lines |
| v_wait | input | 16 | Vertical sync width plus upper porch, in lines |
| v_active | input | 16 | Active lines per frame |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pix_req | output | 1 | Active-high request for one pixel this cycle |
| line_start | output | 1 | First dot clock of each line |
| frame_start | output | 1 | First dot clock of each frame |

## Verification
The bench targets the following corner cases:

- **Active-window edges.** A window that begins at position 0, or that fills the whole line, catches comparisons that are off by one. Such a design would start or end pix_req one pixel early or late.
- **Zero and full sync widths.** These catch a sync that never deasserts, or one that fires when its width is zero.
- **Polarity combinations.** All sixteen combinations of the polarity and drive bits are swept, so any inverted or swapped pin shows at once.
- **Mid-frame configuration writes.** A design without shadowing would bend the current frame after such a write.
- **Stop and restart of the raster.** A design that resumed counting from a stale position would miss the frame_start pulse that must lead a restarted raster.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int HPW  = 18;
  parameter int HSWW = 14;
  parameter int HWTW = 12;
  parameter int HAW  = 18;
  parameter int VPW  = 16;
  parameter int VSWW = 18;
  parameter int VWTW = 16;
  parameter int VAW  = 16;
  // Widths for window arithmetic: widest field on each axis plus one carry bit.
  localparam int HXW = HPW + 1;
  localparam int VXW = VSWW + 1;

  typedef struct packed {
    logic            hs_hi;
    logic            vs_hi;
    logic            de_hi;
    logic            de_drive;
    logic [HPW-1:0]  hper;
    logic [HSWW-1:0] hsw;
    logic [HWTW-1:0] hwait;
    logic [HAW-1:0]  hact;
    logic [VPW-1:0]  vper;
    logic [VSWW-1:0] vsw;
    logic [VWTW-1:0] vwait;
    logic [VAW-1:0]  vact;
  } vtg_cfg_t;
endpackage

// File: rtl/vtg_axis_cnt.sv
module vtg_axis_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         at_end
);
  localparam logic [W:0]   ONE_X = 1;
  localparam logic [W-1:0] INC   = 1;

  logic [W-1:0] cnt_d;

  // cnt+1 >= period, so that a period of 0 behaves as a period of 1.
  always_comb at_end = ({1'b0, cnt} + ONE_X) >= {1'b0, period};

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = at_end ? '0 : cnt + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R10: the position never reaches the held period.
  a_r10_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt < period));
endmodule

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  vtg_cfg_t live,
  output vtg_cfg_t held
);
  vtg_cfg_t held_d;

  always_comb held_d = load ? live : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_d;
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  logic           en,
  input  logic [HPW-1:0] h,
  input  logic [VPW-1:0] v,
  input  vtg_cfg_t       cfg,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           pix_req,
  output logic           line_start,
  output logic           frame_start
);
  logic [HXW-1:0] hx, h_lo, h_hi;
  logic [VXW-1:0] vx, v_lo, v_hi;
  logic           h_win, v_win, hs_act, vs_act, de_act;

  always_comb begin
    hx   = HXW'(h);
    h_lo = HXW'(cfg.hwait);
    h_hi = HXW'(cfg.hwait) + HXW'(cfg.hact);
    vx   = VXW'(v);
    v_lo = VXW'(cfg.vwait);
    v_hi = VXW'(cfg.vwait) + VXW'(cfg.vact);

    h_win  = (hx >= h_lo) && (hx < h_hi);
    v_win  = (vx >= v_lo) && (vx < v_hi);
    hs_act = en && (hx < HXW'(cfg.hsw));
    vs_act = en && (vx < VXW'(cfg.vsw));

    pix_req = en && h_win && v_win;
    de_act  = pix_req && cfg.de_drive;

    hsync_o = hs_act ? cfg.hs_hi : ~cfg.hs_hi;
    vsync_o = vs_act ? cfg.vs_hi : ~cfg.vs_hi;
    de_o    = de_act ? cfg.de_hi : ~cfg.de_hi;

    line_start  = en && (h == '0);
    frame_start = en && (h == '0) && (v == '0);
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_en,
  input  logic            hs_pol_hi,
  input  logic            vs_pol_hi,
  input  logic            de_pol_hi,
  input  logic            de_drive,
  input  logic [HPW-1:0]  line_period,
  input  logic [HSWW-1:0] hsync_width,
  input  logic [HWTW-1:0] h_wait,
  input  logic [HAW-1:0]  h_active,
  input  logic [VPW-1:0]  frame_lines,
  input  logic [VSWW-1:0] vsync_width,
  input  logic [VWTW-1:0] v_wait,
  input  logic [VAW-1:0]  v_active,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            pix_req,
  output logic            line_start,
  output logic            frame_start
);
  vtg_cfg_t       live, held;
  logic           en_q, en_d;
  logic           h_end, v_end, load;
  logic [HPW-1:0] h;
  logic [VPW-1:0] v;

  always_comb begin
    live.hs_hi    = hs_pol_hi;
    live.vs_hi    = vs_pol_hi;
    live.de_hi    = de_pol_hi;
    live.de_drive = de_drive;
    live.hper     = line_period;
    live.hsw      = hsync_width;
    live.hwait    = h_wait;
    live.hact     = h_active;
    live.vper     = frame_lines;
    live.vsw      = vsync_width;
    live.vwait    = v_wait;
    live.vact     = v_active;
  end

  always_comb en_d = sync_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  // Reload while stopped, or on the last dot clock of a frame.
  always_comb load = !en_q || (h_end && v_end);

  vtg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .live(live), .held(held)
  );

  vtg_axis_cnt #(.W(HPW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!en_q), .step(en_q),
    .period(held.hper), .cnt(h), .at_end(h_end)
  );

  vtg_axis_cnt #(.W(VPW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!en_q), .step(en_q && h_end),
    .period(held.vper), .cnt(v), .at_end(v_end)
  );

  vtg_decode u_dec (
    .en(en_q), .h(h), .v(v), .cfg(held),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req(pix_req),
    .line_start(line_start), .frame_start(frame_start)
  );

  // R8: a stopped raster emits no strobes.
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!pix_req && !line_start && !frame_start));

  // R3: a frame start is always also a line start.
  a_r3_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  // R9: the held configuration stays frozen inside a running frame.
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !frame_start) |-> $stable(held));

  // R7: a driven enable pin mirrors the pixel request at its held polarity.
  a_r7_de_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (held.de_drive) |-> (de_o == (pix_req ? held.de_hi : ~held.de_hi)));
endmodule

// File: tb/test_vtg_top.sv
`timescale 1ns/1ps
module test_vtg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sync_en = 1'b0;
  logic hs_pol_hi = 1'b1, vs_pol_hi = 1'b1, de_pol_hi = 1'b1, de_drive = 1'b1;
  logic [17:0] line_period = 18'd10;
  logic [13:0] hsync_width = 14'd2;
  logic [11:0] h_wait = 12'd3;
  logic [17:0] h_active = 18'd5;
  logic [15:0] frame_lines = 16'd6;
  logic [17:0] vsync_width = 18'd1;
  logic [15:0] v_wait = 16'd2;
  logic [15:0] v_active = 16'd3;
  logic hsync_o, vsync_o, de_o, pix_req, line_start, frame_start;

  int tests = 0;
  int fails = 0;
  string phase = "R1";

  // Bench model state.
  int men = 0, mh = 0, mv = 0;
  int s_hper = 0, s_hsw = 0, s_hwait = 0, s_hact = 0;
  int s_vper = 0, s_vsw = 0, s_vwait = 0, s_vact = 0;
  int s_hs = 0, s_vs = 0, s_de = 0, s_drv = 0;

  always #10 clk = ~clk;

  vtg_top i_vtg_top (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
    .hs_pol_hi(hs_pol_hi), .vs_pol_hi(vs_pol_hi), .de_pol_hi(de_pol_hi),
    .de_drive(de_drive), .line_period(line_period), .hsync_width(hsync_width),
    .h_wait(h_wait), .h_active(h_active), .frame_lines(frame_lines),
    .vsync_width(vsync_width), .v_wait(v_wait), .v_active(v_active),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req(pix_req),
    .line_start(line_start), .frame_start(frame_start)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at h=%0d v=%0d: actual %0b expected %0b",
               phase, tag, mh, mv, act, exp);
    end
  endtask

  task automatic load_live();
    s_hper = int'(line_period);  s_hsw = int'(hsync_width);
    s_hwait = int'(h_wait);      s_hact = int'(h_active);
    s_vper = int'(frame_lines);  s_vsw = int'(vsync_width);
    s_vwait = int'(v_wait);      s_vact = int'(v_active);
    s_hs = int'(hs_pol_hi); s_vs = int'(vs_pol_hi);
    s_de = int'(de_pol_hi); s_drv = int'(de_drive);
  endtask

  // Advance the model exactly as the requirements describe one clock edge.
  task automatic model_edge();
    if (men == 0) begin
      mh = 0; mv = 0; load_live();
    end else if (mh + 1 >= s_hper) begin
      mh = 0;
      if (mv + 1 >= s_vper) begin mv = 0; load_live(); end
      else mv++;
    end else mh++;
    men = int'(sync_en);
  endtask

  task automatic compare();
    logic hs_a, vs_a, win, de_a;
    hs_a = (men != 0) && (mh < s_hsw);
    vs_a = (men != 0) && (mv < s_vsw);
    win  = (men != 0) && (mh >= s_hwait) && (mh < s_hwait + s_hact)
           && (mv >= s_vwait) && (mv < s_vwait + s_vact);
    de_a = win && (s_drv != 0);
    chk("R4 hsync", hsync_o, hs_a ? s_hs[0] : ~s_hs[0]);
    chk("R5 vsync", vsync_o, vs_a ? s_vs[0] : ~s_vs[0]);
    chk("R6 pix_req", pix_req, win);
    chk("R7 de", de_o, de_a ? s_de[0] : ~s_de[0]);
    chk("R2 line_start", line_start, (men != 0) && (mh == 0));
    chk("R3 frame_start", frame_start, (men != 0) && (mh == 0) && (mv == 0));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    phase = "R1";
    compare();
    chk("R1 hsync idle", hsync_o, 1'b1);
    chk("R1 de idle", de_o, 1'b1);
    rst_n = 1'b1;

    phase = "R8 stopped";
    run(4);

    phase = "R2 base";
    sync_en = 1'b1;
    run(1);
    chk("R8 first frame_start", frame_start, 1'b1);
    run(130);

    // Sweep polarity and drive bits; each change lands mid-frame (R9).
    for (int p = 0; p < 16; p++) begin
      phase = "R9 polarity";
      {hs_pol_hi, vs_pol_hi, de_pol_hi, de_drive} = 4'(p);
      run(37);
    end

    phase = "R10 full window";
    hsync_width = 14'd0; h_wait = 12'd0; h_active = 18'd7; line_period = 18'd7;
    vsync_width = 18'd5; v_wait = 16'd0; v_active = 16'd5; frame_lines = 16'd5;
    run(100);

    phase = "R10 zero period";
    line_period = 18'd0; frame_lines = 16'd3; h_active = 18'd1; hsync_width = 14'd1;
    run(20);

    phase = "R9 midframe";
    line_period = 18'd12; hsync_width = 14'd3; h_wait = 12'd4; h_active = 18'd6;
    frame_lines = 16'd7; vsync_width = 18'd2; v_wait = 16'd3; v_active = 16'd3;
    run(30);
    line_period = 18'd9; h_wait = 12'd2; v_active = 16'd2;
    run(200);

    phase = "R8 stop";
    sync_en = 1'b0;
    run(6);
    phase = "R8 restart";
    sync_en = 1'b1;
    run(1);
    chk("R8 restart frame_start", frame_start, 1'b1);
    run(80);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule